// File: doc/BRIEF.md
# Multi-Register Stack Pop Sequencer

This block performs a "restore all general registers" operation in hardware. On a start request it walks eight consecutive slots of a stack held in byte-addressed memory, beginning at the supplied stack pointer. It reads one slot at a time through a synchronous read port, and writes the contents into a register file through a write port with per-byte enables. The slot that holds the saved stack pointer is read past and discarded. The running stack pointer advances by one slot size after every slot. It is never taken from the stack image.

A single operand-size input picks the slot width, and that input is latched when a request is accepted. In the wide mode each slot is four bytes and fills a whole register. In the narrow mode each slot is two bytes and only the low half of the destination register is written. When the last slot has been consumed, a one-cycle done pulse marks the end. The final pointer is visible on `sp_o`. The sequencer changes no condition flags.

Top module: `stack_pop_seq`

## Requirements
- R1: Register writes occur in the order of indices 7, 6, 5, 3, 2, 1, 0. The write for slot k (k = 0..7, skipping 3) carries the data read from slot k, and its index is 7 − k.
- R2: Slot 3 (the saved stack pointer) is read but produces no register write: index 4 is never written. The pointer still advances past that slot, so exactly 8 reads and 7 writes occur per operation.
- R3: With `full_i` = 1 the read address of slot k is start + 4·k, modulo 2^AW. The whole little-endian word returned by the memory is written, with all byte enables set.
- R4: With `full_i` = 0 the read address of slot k is start + 2·k, modulo 2^AW. The byte enables are low-half only (0011 for a 32-bit register), and the upper half of the write data is zero.
- R5: When `done_o` is high, `sp_o` equals the start pointer plus 32 (wide mode) or plus 16 (narrow mode), modulo 2^AW.
- R6: `done_o` is high for exactly one cycle, 17 cycles after the clock edge that accepts start, and `busy_o` is low in the next cycle.
- R7: A start request while `busy_o` is high is ignored. The operand size latched at acceptance governs the whole operation.
- R8: Each slot takes two cycles. `mem_req_o` is high for one cycle with the address, and the data is consumed in the next cycle. The first register write appears 2 cycles after the accepting edge.
- R9: A synchronous active-high `rst` returns the block to idle. After reset, `busy_o`, `done_o`, `mem_req_o` and `rf_we_o` are low, even if reset arrives in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a pop-all operation (taken only when idle) |
| full_i | input | 1 | Operand size: 1 = 4-byte slots, 0 = 2-byte slots |
| sp_i | input | AW | Stack pointer at the start of the operation |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Byte address of the slot being read |
| mem_rdata_i | input | XLEN | Little-endian read data, valid the cycle after the request |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_idx_o | output | 3 | Destination register index |
| rf_wdata_o | output | XLEN | Register write data |
| rf_be_o | output | XLEN/8 | Per-byte write enables |
| sp_o | output | AW | Current stack pointer |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with AW = 16 and XLEN = 32. The narrow address space makes pointer wraparound reachable with start values just below 0xFFFF, in both slot widths. Those cases confirm that the slot addresses and the final pointer wrap modulo 2^16. Odd and unaligned start pointers, and start pulses of the opposite size injected during busy operations, bring the latching of the size and the ignoring of requests within reach.

// File: rtl/stack_pop_pkg.sv
package stack_pop_pkg;

  localparam int unsigned NSLOT     = 8;
  localparam int unsigned SLOT_W    = 3;
  localparam int unsigned SKIP_SLOT = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } pop_state_t;

  typedef logic [SLOT_W-1:0] slot_t;

  // bytes consumed by one slot for the given mode and register width
  function automatic int unsigned slot_bytes(input logic full, input int unsigned xlen);
    return full ? (xlen / 8) : (xlen / 16);
  endfunction

  // bytes consumed by a complete operation
  function automatic int unsigned frame_bytes(input logic full, input int unsigned xlen);
    return NSLOT * slot_bytes(full, xlen);
  endfunction

  // destination register for a slot (slots run from the highest index down)
  function automatic logic [2:0] reg_of_slot(input slot_t s);
    return 3'(NSLOT - 1) - s;
  endfunction

  // slot holding the saved stack pointer
  function automatic logic is_sp_slot(input slot_t s);
    return s == slot_t'(SKIP_SLOT);
  endfunction

endpackage

// File: rtl/pop_ctrl.sv
module pop_ctrl
  import stack_pop_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start_i,
  input  logic  full_i,
  output logic  accept_o,
  output logic  issue_o,
  output logic  capture_o,
  output logic  skip_o,
  output logic  full_o,
  output slot_t slot_o,
  output logic  busy_o,
  output logic  done_o
);

  pop_state_t state_q;
  slot_t      slot_q;
  logic       full_q;
  logic       last_slot;

  assign last_slot = (slot_q == slot_t'(NSLOT - 1));
  assign accept_o  = (state_q == ST_IDLE) && start_i;
  assign issue_o   = (state_q == ST_ISSUE);
  assign capture_o = (state_q == ST_WAIT);
  assign skip_o    = is_sp_slot(slot_q);
  assign done_o    = (state_q == ST_DONE);
  assign busy_o    = (state_q != ST_IDLE);
  assign full_o    = full_q;
  assign slot_o    = slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      full_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_ISSUE;
            slot_q  <= '0;
            full_q  <= full_i;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (last_slot) begin
            state_q <= ST_DONE;
          end else begin
            slot_q  <= slot_q + slot_t'(1);
            state_q <= ST_ISSUE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  size_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(full_q));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!done_o && !busy_o));

  // R8
  issue_capture_chk: assert property (@(posedge clk) disable iff (rst)
    issue_o |=> (capture_o && !issue_o));

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o));

endmodule

// File: rtl/pop_ptr.sv
module pop_ptr
  import stack_pop_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned XLEN = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept_i,
  input  logic          advance_i,
  input  logic          full_i,
  input  logic          done_i,
  input  logic [AW-1:0] sp_i,
  output logic [AW-1:0] sp_o
);

  logic [AW-1:0] sp_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] step;

  assign step = AW'(slot_bytes(full_i, XLEN));
  assign sp_o = sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= '0;
      base_q <= '0;
    end else if (accept_i) begin
      sp_q   <= sp_i;
      base_q <= sp_i;
    end else if (advance_i) begin
      sp_q <= sp_q + step;
    end
  end

  // R5
  final_sp_chk: assert property (@(posedge clk) disable iff (rst)
    done_i |-> (sp_q == base_q + AW'(frame_bytes(full_i, XLEN))));

  // R2
  sp_moves_chk: assert property (@(posedge clk) disable iff (rst)
    advance_i |=> (sp_q != $past(sp_q)));

endmodule

// File: rtl/pop_wrfmt.sv
module pop_wrfmt
  import stack_pop_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 capture_i,
  input  logic                 skip_i,
  input  logic                 full_i,
  input  slot_t                slot_i,
  input  logic [XLEN-1:0]      rdata_i,
  output logic                 rf_we_o,
  output logic [2:0]           rf_idx_o,
  output logic [XLEN-1:0]      rf_wdata_o,
  output logic [XLEN/8-1:0]    rf_be_o
);

  localparam int unsigned NB = XLEN / 8;

  assign rf_we_o  = capture_i && !skip_i;
  assign rf_idx_o = reg_of_slot(slot_i);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    localparam bit LOW_HALF = (g < NB / 2);
    assign rf_be_o[g]          = full_i || LOW_HALF;
    assign rf_wdata_o[8*g +: 8] = rf_be_o[g] ? rdata_i[8*g +: 8] : 8'h00;
  end

  // R2
  no_sp_write_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (rf_idx_o != 3'd4));

  // R4
  half_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we_o && !full_i) |-> ($countones(rf_be_o) == NB / 2 && rf_be_o[0]));

  // R3
  full_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we_o && full_i) |-> (&rf_be_o));

endmodule

// File: rtl/stack_pop_seq.sv
module stack_pop_seq
  import stack_pop_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              full_i,
  input  logic [AW-1:0]     sp_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic              rf_we_o,
  output logic [2:0]        rf_idx_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic [XLEN/8-1:0] rf_be_o,
  output logic [AW-1:0]     sp_o,
  output logic              busy_o,
  output logic              done_o
);

  logic  accept;
  logic  issue;
  logic  capture;
  logic  skip;
  logic  full_q;
  slot_t slot;
  logic [AW-1:0] sp_cur;

  pop_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .full_i    (full_i),
    .accept_o  (accept),
    .issue_o   (issue),
    .capture_o (capture),
    .skip_o    (skip),
    .full_o    (full_q),
    .slot_o    (slot),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  pop_ptr #(.AW(AW), .XLEN(XLEN)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .accept_i  (accept),
    .advance_i (capture),
    .full_i    (full_q),
    .done_i    (done_o),
    .sp_i      (sp_i),
    .sp_o      (sp_cur)
  );

  pop_wrfmt #(.XLEN(XLEN)) u_wrfmt (
    .clk        (clk),
    .rst        (rst),
    .capture_i  (capture),
    .skip_i     (skip),
    .full_i     (full_q),
    .slot_i     (slot),
    .rdata_i    (mem_rdata_i),
    .rf_we_o    (rf_we_o),
    .rf_idx_o   (rf_idx_o),
    .rf_wdata_o (rf_wdata_o),
    .rf_be_o    (rf_be_o)
  );

  assign mem_req_o  = issue;
  assign mem_addr_o = sp_cur;
  assign sp_o       = sp_cur;

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!rf_we_o && !mem_req_o));

  // R8
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !mem_req_o);

endmodule

// File: tb/test_stack_pop_seq.sv
module test_stack_pop_seq;

  localparam int unsigned AW   = 16;
  localparam int unsigned XLEN = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic              full_i = 1'b0;
  logic [AW-1:0]     sp_i = '0;
  logic              mem_req_o;
  logic [AW-1:0]     mem_addr_o;
  logic [XLEN-1:0]   mem_rdata_i = '0;
  logic              rf_we_o;
  logic [2:0]        rf_idx_o;
  logic [XLEN-1:0]   rf_wdata_o;
  logic [XLEN/8-1:0] rf_be_o;
  logic [AW-1:0]     sp_o;
  logic              busy_o;
  logic              done_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // operation bookkeeping
  logic          in_op = 1'b0;
  logic          op_full = 1'b0;
  logic [AW-1:0] op_sp = '0;
  int            op_start = 0;
  int            req_n = 0;
  int            wr_n = 0;
  logic          op_done = 1'b0;
  logic [7:0]    salt = 8'h00;

  always #4 clk = ~clk;   // 125 MHz

  stack_pop_seq #(.AW(AW), .XLEN(XLEN)) i_stack_pop_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .full_i(full_i), .sp_i(sp_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .rf_we_o(rf_we_o), .rf_idx_o(rf_idx_o), .rf_wdata_o(rf_wdata_o),
    .rf_be_o(rf_be_o), .sp_o(sp_o), .busy_o(busy_o), .done_o(done_o)
  );

  // ---- bench model of memory contents and expectations ----
  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return 8'(a[7:0] * 8'd29) ^ 8'(a[15:8] * 8'd7) ^ salt;
  endfunction

  function automatic logic [XLEN-1:0] mem_word(input logic [AW-1:0] a);
    logic [XLEN-1:0] w;
    for (int i = 0; i < XLEN / 8; i++) w[8*i +: 8] = mem_byte(a + AW'(i));
    return w;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] sp, input logic full, input int k);
    return sp + AW'(k * (full ? 4 : 2));
  endfunction

  function automatic int slot_of_write(input int w);
    return (w < 3) ? w : w + 1;
  endfunction

  function automatic logic [2:0] exp_idx(input int w);
    case (w)
      0: return 3'd7;
      1: return 3'd6;
      2: return 3'd5;
      3: return 3'd3;
      4: return 3'd2;
      5: return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req_o) mem_rdata_i <= mem_word(mem_addr_o);
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---- monitor ----
  always @(negedge clk) begin
    if (!rst) begin
      if (!in_op) begin
        if (rf_we_o || mem_req_o || done_o)
          check(1'b0, "R9", "activity while idle", {29'd0, rf_we_o, mem_req_o, done_o}, 32'd0);
      end else begin
        if (mem_req_o) begin
          // R3 R4 slot addresses
          check(mem_addr_o == exp_addr(op_sp, op_full, req_n), op_full ? "R3" : "R4",
                "read address", 32'(mem_addr_o), 32'(exp_addr(op_sp, op_full, req_n)));
          req_n++;
        end
        if (rf_we_o) begin
          logic [XLEN-1:0] w;
          w = mem_word(exp_addr(op_sp, op_full, slot_of_write(wr_n)));
          if (!op_full) w = {16'h0000, w[15:0]};
          if (wr_n == 0)
            check(cyc - op_start == 2, "R8", "first write latency", 32'(cyc - op_start), 32'd2);
          check(rf_idx_o == exp_idx(wr_n), "R1", "register order", 32'(rf_idx_o), 32'(exp_idx(wr_n)));
          check(rf_wdata_o == w, op_full ? "R3" : "R4", "write data", rf_wdata_o, w);
          check(rf_be_o == (op_full ? 4'hF : 4'h3), op_full ? "R3" : "R4", "byte enables",
                32'(rf_be_o), op_full ? 32'hF : 32'h3);
          wr_n++;
        end
        if (done_o) begin
          logic [AW-1:0] fin;
          fin = op_sp + AW'(op_full ? 32 : 16);
          check(wr_n == 7 && req_n == 8, "R2", "writes/reads per op", 32'(wr_n * 16 + req_n), 32'h78);
          check(sp_o == fin, "R5", "final pointer", 32'(sp_o), 32'(fin));
          check(cyc - op_start == 17, "R6", "done timing", 32'(cyc - op_start), 32'd17);
          op_done = 1'b1;
          in_op = 1'b0;
        end
      end
    end
  end

  // ---- stimulus ----
  task automatic run_op(input logic [AW-1:0] sp, input logic full, input logic noise);
    @(negedge clk);
    op_sp = sp; op_full = full; op_start = cyc; req_n = 0; wr_n = 0;
    op_done = 1'b0; salt = 8'($urandom); in_op = 1'b1;
    start_i = 1'b1; full_i = full; sp_i = sp;
    @(negedge clk);
    start_i = 1'b0; sp_i = AW'($urandom);
    for (int i = 0; i < 40 && !op_done; i++) begin
      // R7: opposite-size requests during a busy operation
      start_i = noise && ($urandom % 3 == 0) && busy_o;
      full_i  = !full;
      @(negedge clk);
      if (op_done) start_i = 1'b0;
    end
    start_i = 1'b0;
    check(op_done, "R6", "done seen", 32'(op_done), 32'd1);
    check(!busy_o && !done_o, "R6", "idle after done", {30'd0, busy_o, done_o}, 32'd0);
    in_op = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 100000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(!busy_o && !done_o && !mem_req_o && !rf_we_o, "R9", "reset state",
          {28'd0, busy_o, done_o, mem_req_o, rf_we_o}, 32'd0);

    // directed corners
    run_op(16'h0100, 1'b1, 1'b0);
    run_op(16'h0100, 1'b0, 1'b0);
    run_op(16'hFFF8, 1'b1, 1'b0);   // wrap in wide mode
    run_op(16'hFFFC, 1'b0, 1'b0);   // wrap in narrow mode
    run_op(16'h1235, 1'b1, 1'b1);   // unaligned, noisy starts
    run_op(16'h0003, 1'b0, 1'b1);

    // reset in the middle of an operation
    @(negedge clk);
    in_op = 1'b1; op_sp = 16'h0400; op_full = 1'b1; op_start = cyc; req_n = 0; wr_n = 0;
    start_i = 1'b1; full_i = 1'b1; sp_i = 16'h0400;
    @(negedge clk); start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1; in_op = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o && !mem_req_o && !rf_we_o, "R9", "mid-op reset",
          {28'd0, busy_o, done_o, mem_req_o, rf_we_o}, 32'd0);
    repeat (20) @(negedge clk);

    // constrained random
    for (int n = 0; n < 40; n++)
      run_op(AW'($urandom), 1'($urandom), 1'($urandom));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule